// File: doc/BRIEF.md
# Receive line frame-pulse synchronizer

This block terminates a 16-bit parallel receive line bus carrying a 10 Gb/s SONET/SDH frame stream. It registers the data word, an external frame-pulse line and a parity bit on every rising edge of the line clock. It checks the parity of each word. It also takes frame alignment from the rising edge of the external pulse instead of hunting for the framing pattern. From that edge it keeps a row counter and a column counter, counted in 16-bit words, which tell downstream overhead and payload logic where each word sits in the frame.

The pulse edge can mark one of two points. In one mode it marks the word that carries the first framing byte on the upper lane. In the other mode it marks the first payload word, whose column offset is programmable. Once locked, the counters run freely. A later edge at the predicted position confirms the alignment. An edge anywhere else raises a misalignment strobe and the counters restart from the new edge. Parity errors produce a strobe that lines up with the failing word, and a saturating error counter.

Top module: `rxl_fp_sync`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, every output is zero.
- R2: Each sampled data word appears unchanged on `rx_data` two clock edges after it is applied. Bit 15 is the first serial bit and stays the most significant bit. Row, column, start-of-frame, misalignment and parity-error outputs all refer to the word on `rx_data` in the same cycle.
- R3: With `cfg_payload_ref`=0, the word sampled with a 0-to-1 transition of `line_fp` is reported at row 0, column 0, and `rx_sof` is 1 with it.
- R4: With `cfg_payload_ref`=1, the word that carries the pulse edge is reported at row 0, column `cfg_pay_col`. `rx_sof` then marks the later word that reaches row 0, column 0.
- R5: Only the rising edge of `line_fp` matters. A pulse that stays high for several cycles neither restarts nor disturbs the counters.
- R6: After lock, the column advances by one for every word and wraps from COLS-1 to 0. Each wrap advances the row, and the row wraps from ROWS-1 to 0. `rx_sof` is 1 on every word at row 0, column 0, even when no new pulse arrives. Before the first edge, row and column stay 0 and `rx_sof` stays 0.
- R7: When a locked block sees an edge on the word whose predicted position equals the reference position, `rx_misalign` stays 0 and the counting goes on as before.
- R8: When a locked block sees an edge at any other position, `rx_misalign` is 1 for that one word and the counters restart from the reference position. The first edge after reset never raises `rx_misalign`.
- R9: With `cfg_odd_par`=0, a word has an error unless the XOR of its 16 data bits and `line_par` is 0. With `cfg_odd_par`=1, a word has an error unless that XOR is 1. `rx_par_err` is 1 for exactly the failing words.
- R10: With `cfg_par_fp`=1, the `line_fp` sample is also included in the parity XOR. With `cfg_par_fp`=0, `line_fp` has no effect on the parity result.
- R11: Each failing word increments `rx_err_cnt` on the edge that raises `rx_par_err`. The counter stops at 2^ERR_W-1 and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock, rising edge samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| line_data | input | 16 | Receive data word, bit 15 first on the serial line |
| line_fp | input | 1 | External frame pulse, rising edge marks alignment |
| line_par | input | 1 | Parity bit for the word |
| cfg_payload_ref | input | 1 | 0: edge marks the first framing word, 1: edge marks the first payload word |
| cfg_odd_par | input | 1 | 0: even parity, 1: odd parity |
| cfg_par_fp | input | 1 | 1: frame pulse included in the parity check |
| cfg_pay_col | input | $clog2(COLS) | Column of the first payload word, must be below COLS |
| rx_data | output | 16 | Aligned data word |
| rx_sof | output | 1 | Word is at row 0, column 0 |
| rx_row | output | $clog2(ROWS) | Row of the word |
| rx_col | output | $clog2(COLS) | Column of the word, in 16-bit words |
| rx_misalign | output | 1 | Pulse edge seen away from its predicted position |
| rx_par_err | output | 1 | Parity failure on the word |
| rx_err_cnt | output | ERR_W | Saturating parity error count |

## Verification
The bench drives a pulse that stays high for three words. A design that keyed on the level instead of the edge would restart the columns at every high word. The bench also drives a confirming pulse exactly on the frame wrap, where an off-by-one in the predicted position would raise a false misalignment, and a pulse placed mid-row, which has to raise the strobe once and restart the count. In payload-reference mode, start-of-frame must fall on the word where the preset column wraps to zero, so a counter that ignored the offset would flag the wrong word. The parity runs toggle the pulse line in both settings of the pulse-inclusion bit and flip the sense between even and odd. Those runs then drive the error counter into saturation, where a wrapping counter would fall back to zero.

// File: rtl/rxl_fp_pkg.sv
package rxl_fp_pkg;

    typedef enum logic {
        REF_FIRST_A1 = 1'b0,
        REF_PAYLOAD  = 1'b1
    } fp_ref_e;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_sense_e;

    function automatic logic rise(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

    function automatic logic parity_fault(input logic       data_xor,
                                          input logic       fp_bit,
                                          input logic       par_bit,
                                          input par_sense_e sense,
                                          input logic       incl_fp);
        logic total;
        total = data_xor ^ par_bit ^ (incl_fp & fp_bit);
        return total != logic'(sense);
    endfunction

endpackage

// File: rtl/rxl_fp_capture.sv
module rxl_fp_capture
    import rxl_fp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] line_data,
    input  logic          line_fp,
    input  logic          line_par,
    input  par_sense_e    sense,
    input  logic          incl_fp,
    output logic [DW-1:0] s1_data,
    output logic          fp_edge,
    output logic          par_fault
);

    logic s1_fp;
    logic s1_par;
    logic fp_prev;
    logic s1_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_data <= '0;
            s1_fp   <= 1'b0;
            s1_par  <= 1'b0;
            fp_prev <= 1'b0;
            s1_vld  <= 1'b0;
        end else begin
            s1_data <= line_data;
            s1_fp   <= line_fp;
            s1_par  <= line_par;
            fp_prev <= s1_fp;
            s1_vld  <= 1'b1;
        end
    end

    assign fp_edge   = rise(s1_fp, fp_prev);
    assign par_fault = s1_vld & parity_fault(^s1_data, s1_fp, s1_par, sense, incl_fp);

    // R5: an edge can never be seen on two consecutive words
    assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
        fp_edge |=> !fp_edge);

endmodule

// File: rtl/rxl_fp_locator.sv
module rxl_fp_locator
    import rxl_fp_pkg::*;
#(
    parameter int ROWS = 9,
    parameter int COLS = 8640
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fp_edge,
    input  fp_ref_e                 ref_sel,
    input  logic [$clog2(COLS)-1:0] pay_col,
    output logic [$clog2(ROWS)-1:0] row_o,
    output logic [$clog2(COLS)-1:0] col_o,
    output logic                    sof_o,
    output logic                    mis_o
);

    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } pos_t;

    pos_t cur_q;
    pos_t nxt_pred;
    pos_t ref_pos;
    pos_t pos_d;
    logic locked_q;
    logic sof_d;
    logic mis_d;
    logic sof_q;
    logic mis_q;

    always_comb begin
        ref_pos.row = '0;
        ref_pos.col = (ref_sel == REF_PAYLOAD) ? pay_col : '0;

        nxt_pred = cur_q;
        if (cur_q.col == COL_LAST) begin
            nxt_pred.col = '0;
            nxt_pred.row = (cur_q.row == ROW_LAST) ? '0 : cur_q.row + 1'b1;
        end else begin
            nxt_pred.col = cur_q.col + 1'b1;
        end

        mis_d = 1'b0;
        if (fp_edge) begin
            pos_d = ref_pos;
            mis_d = locked_q && (nxt_pred != ref_pos);
        end else if (locked_q) begin
            pos_d = nxt_pred;
        end else begin
            pos_d = '0;
        end
        sof_d = (fp_edge || locked_q) && (pos_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            locked_q <= 1'b0;
            sof_q    <= 1'b0;
            mis_q    <= 1'b0;
        end else begin
            cur_q    <= pos_d;
            locked_q <= locked_q | fp_edge;
            sof_q    <= sof_d;
            mis_q    <= mis_d;
        end
    end

    assign row_o = cur_q.row;
    assign col_o = cur_q.col;
    assign sof_o = sof_q;
    assign mis_o = mis_q;

    // R6: counters stay inside the frame bounds
    assert_col_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(cur_q.col) < COLS);
    assert_row_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(cur_q.row) < ROWS);

    // R8: a misalignment needs an earlier lock
    assert_mis_locked_R8: assert property (@(posedge clk) disable iff (rst)
        mis_q |-> $past(locked_q));

endmodule

// File: rtl/rxl_fp_errcnt.sv
module rxl_fp_errcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

    // R11: saturation holds and the count moves only on an error
    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_q) == TOP) |-> (cnt_q == TOP));
    assert_moves_on_err_R11: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> $past(inc));

endmodule

// File: rtl/rxl_fp_sync.sv
module rxl_fp_sync
    import rxl_fp_pkg::*;
#(
    parameter int ROWS  = 9,
    parameter int COLS  = 8640,
    parameter int ERR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [15:0]             line_data,
    input  logic                    line_fp,
    input  logic                    line_par,
    input  logic                    cfg_payload_ref,
    input  logic                    cfg_odd_par,
    input  logic                    cfg_par_fp,
    input  logic [$clog2(COLS)-1:0] cfg_pay_col,
    output logic [15:0]             rx_data,
    output logic                    rx_sof,
    output logic [$clog2(ROWS)-1:0] rx_row,
    output logic [$clog2(COLS)-1:0] rx_col,
    output logic                    rx_misalign,
    output logic                    rx_par_err,
    output logic [ERR_W-1:0]        rx_err_cnt
);

    localparam int DW = 16;

    logic [DW-1:0] s1_data;
    logic          fp_edge;
    logic          par_fault;

    rxl_fp_capture #(.DW(DW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .line_data (line_data),
        .line_fp   (line_fp),
        .line_par  (line_par),
        .sense     (par_sense_e'(cfg_odd_par)),
        .incl_fp   (cfg_par_fp),
        .s1_data   (s1_data),
        .fp_edge   (fp_edge),
        .par_fault (par_fault)
    );

    rxl_fp_locator #(.ROWS(ROWS), .COLS(COLS)) u_loc (
        .clk     (clk),
        .rst     (rst),
        .fp_edge (fp_edge),
        .ref_sel (fp_ref_e'(cfg_payload_ref)),
        .pay_col (cfg_pay_col),
        .row_o   (rx_row),
        .col_o   (rx_col),
        .sof_o   (rx_sof),
        .mis_o   (rx_misalign)
    );

    rxl_fp_errcnt #(.W(ERR_W)) u_err (
        .clk (clk),
        .rst (rst),
        .inc (par_fault),
        .cnt (rx_err_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data    <= '0;
            rx_par_err <= 1'b0;
        end else begin
            rx_data    <= s1_data;
            rx_par_err <= par_fault;
        end
    end

    // R3: start of frame only at the frame origin
    assert_sof_origin_R3: assert property (@(posedge clk) disable iff (rst)
        rx_sof |-> (rx_row == '0 && rx_col == '0));

    // R4: a resync in payload mode lands on the programmed column
    assert_payload_ref_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_misalign && $past(cfg_payload_ref)) |-> (rx_row == '0 && rx_col == $past(cfg_pay_col)));

    // R11: a flagged word below saturation adds exactly one
    assert_perr_counted_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_par_err && ($past(rx_err_cnt) != {ERR_W{1'b1}})) |->
            (rx_err_cnt == ERR_W'($past(rx_err_cnt) + 1'b1)));

endmodule

// File: tb/rxl_fp_sync_test.sv
module rxl_fp_sync_test;

    localparam int T_ROWS  = 3;
    localparam int T_COLS  = 10;
    localparam int T_ERR_W = 4;
    localparam int T_FRAME = T_ROWS * T_COLS;
    localparam int T_MAX   = (1 << T_ERR_W) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] line_data = '0;
    logic        line_fp = 1'b0;
    logic        line_par = 1'b0;
    logic        cfg_payload_ref = 1'b0;
    logic        cfg_odd_par = 1'b0;
    logic        cfg_par_fp = 1'b0;
    logic [3:0]  cfg_pay_col = '0;
    logic [15:0] rx_data;
    logic        rx_sof;
    logic [1:0]  rx_row;
    logic [3:0]  rx_col;
    logic        rx_misalign;
    logic        rx_par_err;
    logic [3:0]  rx_err_cnt;

    int checks = 0;
    int failures = 0;
    int ecnt = 0;

    always #2 clk = ~clk;

    rxl_fp_sync #(.ROWS(T_ROWS), .COLS(T_COLS), .ERR_W(T_ERR_W)) uut (
        .clk(clk), .rst(rst), .line_data(line_data), .line_fp(line_fp),
        .line_par(line_par), .cfg_payload_ref(cfg_payload_ref),
        .cfg_odd_par(cfg_odd_par), .cfg_par_fp(cfg_par_fp),
        .cfg_pay_col(cfg_pay_col), .rx_data(rx_data), .rx_sof(rx_sof),
        .rx_row(rx_row), .rx_col(rx_col), .rx_misalign(rx_misalign),
        .rx_par_err(rx_par_err), .rx_err_cnt(rx_err_cnt)
    );

    function automatic logic [15:0] wd(input int k);
        return 16'(k * 257) ^ 16'hF628;
    endfunction

    function automatic logic good_par(input logic [15:0] d, input logic fp);
        return cfg_odd_par ^ (^d) ^ (cfg_par_fp & fp);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive one word at the falling edge; outputs then show the word from two calls earlier
    task automatic tick(input logic [15:0] d, input logic fp, input logic bad);
        @(negedge clk);
        line_data = d;
        line_fp   = fp;
        line_par  = good_par(d, fp) ^ bad;
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk("R1", "data", 32'(rx_data), 0);
        chk("R1", "sof", 32'(rx_sof), 0);
        chk("R1", "row", 32'(rx_row), 0);
        chk("R1", "col", 32'(rx_col), 0);
        chk("R1", "misalign", 32'(rx_misalign), 0);
        chk("R1", "par_err", 32'(rx_par_err), 0);
        chk("R1", "err_cnt", 32'(rx_err_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "sof after release", 32'(rx_sof), 0);
        chk("R6", "col before lock", 32'(rx_col), 0);
    endtask

    // long pulse at word 0, confirming pulse on the frame wrap at word 30
    task automatic t_a1_frames;
        for (int i = 0; i < 68; i++) begin
            tick(wd(i), (i < 3) || (i == 30) || (i == 31), 1'b0);
            if (i >= 2) begin
                int j;
                j = i - 2;
                chk("R2", "data", 32'(rx_data), 32'(wd(j)));
                chk("R6", "row", 32'(rx_row), 32'((j / T_COLS) % T_ROWS));
                chk(j < 3 ? "R5" : "R6", "col", 32'(rx_col), 32'(j % T_COLS));
                chk(j == 0 ? "R3" : "R6", "sof", 32'(rx_sof), 32'(j % T_FRAME == 0));
                chk(j == 30 ? "R7" : "R5", "misalign", 32'(rx_misalign), 0);
            end
        end
    endtask

    // pulse away from the predicted position (row 0 column 8 predicted next)
    task automatic t_misalign;
        for (int i = 0; i < 18; i++) begin
            tick(wd(i + 100), i < 2, 1'b0);
            if (i >= 2) begin
                int j;
                j = i - 2;
                chk("R8", "misalign", 32'(rx_misalign), 32'(j == 0));
                chk("R8", "row", 32'(rx_row), 32'((j / T_COLS) % T_ROWS));
                chk("R8", "col", 32'(rx_col), 32'(j % T_COLS));
                chk("R2", "data", 32'(rx_data), 32'(wd(j + 100)));
            end
        end
    endtask

    // payload reference at column 7; second pulse at its predicted position
    task automatic t_payload;
        cfg_payload_ref = 1'b1;
        cfg_pay_col     = 4'd7;
        for (int i = 0; i < 42; i++) begin
            tick(wd(i + 200), (i == 0) || (i == 30), 1'b0);
            if (i >= 2) begin
                int j;
                int idx;
                j   = i - 2;
                idx = j + 7;
                chk("R4", "row", 32'(rx_row), 32'((idx / T_COLS) % T_ROWS));
                chk("R4", "col", 32'(rx_col), 32'(idx % T_COLS));
                chk("R4", "sof", 32'(rx_sof), 32'(idx % T_FRAME == 0));
                chk(j == 30 ? "R7" : "R8", "misalign", 32'(rx_misalign), 32'(j == 0));
            end
        end
        cfg_payload_ref = 1'b0;
    endtask

    task automatic t_parity(input logic odd, input logic incl, input int seed, input string req);
        cfg_odd_par = odd;
        cfg_par_fp  = incl;
        repeat (3) tick(wd(seed), 1'b0, 1'b0);
        ecnt = int'(rx_err_cnt);
        for (int i = 0; i < 12; i++) begin
            logic bad_i;
            bad_i = (i < 10) && (((i * 5 + seed) % 3) == 0);
            tick(wd(i + seed), (i % 3) == 1, bad_i);
            if (i >= 2) begin
                int j;
                logic bad_j;
                j     = i - 2;
                bad_j = ((j * 5 + seed) % 3) == 0;
                if (bad_j && ecnt < T_MAX) ecnt++;
                chk(req, "par_err", 32'(rx_par_err), 32'(bad_j));
                chk("R11", "err_cnt", 32'(rx_err_cnt), 32'(ecnt));
            end
        end
    endtask

    task automatic t_saturate;
        cfg_odd_par = 1'b0;
        cfg_par_fp  = 1'b0;
        repeat (3) tick(wd(7), 1'b0, 1'b0);
        for (int i = 0; i < 22; i++) tick(wd(i), 1'b0, i < 20);
        chk("R11", "par_err at saturation", 32'(rx_par_err), 1);
        chk("R11", "saturated count", 32'(rx_err_cnt), T_MAX);
        tick(wd(1), 1'b0, 1'b0);
        tick(wd(2), 1'b0, 1'b0);
        chk("R11", "held count", 32'(rx_err_cnt), T_MAX);
        chk("R9", "clean word", 32'(rx_par_err), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_a1_frames();
        t_misalign();
        t_payload();
        t_parity(1'b0, 1'b0, 40, "R9");
        t_parity(1'b1, 1'b0, 61, "R9");
        t_parity(1'b0, 1'b1, 83, "R10");
        t_parity(1'b1, 1'b1, 95, "R10");
        t_saturate();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule